// File: doc/BRIEF.md
# Encoded Level Interrupt Latch

This block sits between two groups of four active-low external interrupt pins and a CPU's interrupt input. Each group carries a 4-bit priority code. The block synchronizes the pins and filters out codes that are not stable. It masks new detections, then picks the highest level across the groups. That level is presented to the CPU, together with the group it came from and a request flag. The flag is raised only when the level beats the CPU's current interrupt mask level.

There are two operating modes. In retaining mode, each group keeps the highest level it has detected. The held level survives a withdrawn or lowered pin code, and it is released only when the CPU accepts an interrupt or software strobes that group's clear bit. In pass-through mode, nothing is held and the presented level follows the filtered pins. When the CPU accepts while mask update is enabled, the block loads the accepted level into the mask level it returns to the CPU. Either group can be taken out of level arbitration, so that its pins can serve as plain interrupt lines elsewhere.

Top module: `irl_level_latch`

## Requirements
- R1: Pins are active-low. Group 0 is pins 3..0 and group 1 is pins 7..4. A group code of all ones means no request. Any other code c gives level ~c (1 to 15). Out of reset, pend_lvl_o, pend_req_o, pend_src_o and imask_o are all 0.
- R2: Each group passes through two synchronizer flops. A code is detected only when the last two synchronized samples agree. In pass-through mode, a code applied before clock edge k shows up on pend_lvl_o after edge k+2 and not before, and a code held for a single cycle is never detected.
- R3: In retaining mode (lvl_mode_i = 0), a detected level stays presented after the pins withdraw the request or drop to a lower level.
- R4: In retaining mode, a higher detected level replaces the held level of its group, and a lower one never does.
- R5: A cpu_ack_i pulse releases the held levels of both groups on that edge.
- R6: A grp_clr_i pulse releases only that group's held level (bit 0 for group 0, bit 1 for group 1).
- R7: Setting lvl_mask_i bit n blocks new detection of level n. Setting grp_mask_i bit g blocks new detection in group g. Neither mask releases a level that is already held.
- R8: In pass-through mode (lvl_mode_i = 1), nothing is retained. A withdrawn request drops pend_lvl_o back to 0.
- R9: grp_irq_mode_i bit g = 1 removes group g from arbitration, and its level contributes 0.
- R10: pend_lvl_o is the highest group level. pend_src_o is 0 for group 0 and 1 for group 1. On a tie, group 0 wins.
- R11: pend_req_o is 1 exactly when pend_lvl_o > imask_o.
- R12: On cpu_ack_i with mask_upd_en_i = 1 and pend_req_o = 1, imask_o is loaded with pend_lvl_o. With mask_upd_en_i = 0, imask_o is unchanged. imask_ld_i loads imask_val_i, and takes precedence over an acceptance on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irl_pins_ni | input | 8 | Encoded level pins, active low, group g at bits 4g+3..4g |
| lvl_mode_i | input | 1 | 0 retaining, 1 pass-through |
| grp_irq_mode_i | input | 2 | Per-group removal from level arbitration |
| grp_mask_i | input | 2 | Per-group block of new detection |
| lvl_mask_i | input | 16 | Per-level block of new detection |
| grp_clr_i | input | 2 | Per-group release strobe for the held level |
| cpu_ack_i | input | 1 | CPU interrupt-accept strobe |
| mask_upd_en_i | input | 1 | Load accepted level into the mask level on acceptance |
| imask_ld_i | input | 1 | Direct load strobe for the mask level |
| imask_val_i | input | 4 | Value for the direct mask-level load |
| pend_lvl_o | output | 4 | Presented level, 0 when none |
| pend_src_o | output | 1 | Group that supplies pend_lvl_o |
| pend_req_o | output | 1 | Request to the CPU |
| imask_o | output | 4 | CPU interrupt mask level |

## Verification
The hold assertions assume that cpu_ack_i, grp_clr_i and imask_ld_i are pulses the CPU or software raises for one cycle at a time. They also assume that software withdraws a pin code before it strobes a clear; otherwise the still-present code is detected again one edge later. The bench changes pins, modes, masks and strobes only on falling edges. It raises each strobe for exactly one cycle, and it never lets an acceptance and a direct mask load coincide except where the precedence in R12 is the point of the test.

// File: rtl/irl_latch_pkg.sv
package irl_latch_pkg;
  localparam int unsigned LVL_W  = 4;
  localparam int unsigned GROUPS = 2;
  typedef enum logic {MODE_RETAIN = 1'b0, MODE_PASS = 1'b1} lvl_mode_e;
endpackage

// File: rtl/irl_pin_filter.sv
module irl_pin_filter #(
  parameter int LVL_W = irl_latch_pkg::LVL_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LVL_W-1:0]       pins_ni,
  input  logic                   en_i,
  input  logic [(1<<LVL_W)-1:0]  lvl_mask_i,
  output logic [LVL_W-1:0]       det_o
);
  logic [LVL_W-1:0] s1_q, s2_q, s3_q;
  logic [LVL_W-1:0] code_lvl;

  // s1/s2 synchronize, s3 is the previous sample for the stability check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= pins_ni;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    code_lvl = ~s2_q;
    det_o    = '0;
    if ((s2_q == s3_q) && en_i && !lvl_mask_i[code_lvl]) det_o = code_lvl;
  end
endmodule

// File: rtl/irl_group_hold.sv
module irl_group_hold #(
  parameter int LVL_W = irl_latch_pkg::LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] det_i,
  input  logic             pass_i,
  input  logic             ack_i,
  input  logic             clr_i,
  input  logic             off_i,
  output logic [LVL_W-1:0] lvl_o
);
  logic [LVL_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hold_q <= '0;
    else if (pass_i || ack_i || clr_i)  hold_q <= '0;
    else if (det_i > hold_q)            hold_q <= det_i;
  end

  always_comb begin
    if (off_i)       lvl_o = '0;
    else if (pass_i) lvl_o = det_i;
    else             lvl_o = hold_q;
  end

  assert_hold_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass_i && !ack_i && !clr_i) |=> (hold_q >= $past(hold_q)));

  assert_hold_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass_i && !ack_i && !clr_i) |=> (hold_q >= $past(det_i)));

  assert_hold_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i || clr_i) |=> (hold_q == '0));

  assert_pass_no_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_i && !off_i) |-> (lvl_o == det_i));
endmodule

// File: rtl/irl_arbiter.sv
module irl_arbiter #(
  parameter int GROUPS = irl_latch_pkg::GROUPS,
  parameter int LVL_W  = irl_latch_pkg::LVL_W,
  parameter int SRC_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [GROUPS-1:0][LVL_W-1:0] lvl_i,
  input  logic                        ack_i,
  input  logic                        upd_en_i,
  input  logic                        imask_ld_i,
  input  logic [LVL_W-1:0]            imask_val_i,
  output logic [LVL_W-1:0]            pend_lvl_o,
  output logic [SRC_W-1:0]            pend_src_o,
  output logic                        pend_req_o,
  output logic [LVL_W-1:0]            imask_o
);
  logic [LVL_W-1:0] imask_q;

  // strict compare: lower group index keeps a tie
  always_comb begin
    pend_lvl_o = '0;
    pend_src_o = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (lvl_i[g] > pend_lvl_o) begin
        pend_lvl_o = lvl_i[g];
        pend_src_o = SRC_W'(g);
      end
    end
  end

  assign pend_req_o = (pend_lvl_o > imask_q);
  assign imask_o    = imask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   imask_q <= '0;
    else if (imask_ld_i)                           imask_q <= imask_val_i;
    else if (ack_i && upd_en_i && pend_req_o)      imask_q <= pend_lvl_o;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    assert_pick_max_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_lvl_o >= lvl_i[g]);
    assert_src_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_src_o == SRC_W'(g)) |-> (lvl_i[g] == pend_lvl_o));
  end

  assert_tie_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i[0] == pend_lvl_o) |-> (pend_src_o == '0));

  assert_req_above_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_req_o |-> (pend_lvl_o > imask_o));

  assert_req_below_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_req_o |-> (pend_lvl_o <= imask_o));

  assert_imask_load_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && upd_en_i && pend_req_o && !imask_ld_i) |=> (imask_o == $past(pend_lvl_o)));

  assert_imask_keep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ack_i && upd_en_i) && !imask_ld_i) |=> $stable(imask_o));
endmodule

// File: rtl/irl_level_latch.sv
module irl_level_latch #(
  parameter int GROUPS = irl_latch_pkg::GROUPS,
  parameter int LVL_W  = irl_latch_pkg::LVL_W,
  parameter int NLVL   = 1 << LVL_W,
  parameter int SRC_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [GROUPS*LVL_W-1:0]  irl_pins_ni,
  input  logic                     lvl_mode_i,
  input  logic [GROUPS-1:0]        grp_irq_mode_i,
  input  logic [GROUPS-1:0]        grp_mask_i,
  input  logic [NLVL-1:0]          lvl_mask_i,
  input  logic [GROUPS-1:0]        grp_clr_i,
  input  logic                     cpu_ack_i,
  input  logic                     mask_upd_en_i,
  input  logic                     imask_ld_i,
  input  logic [LVL_W-1:0]         imask_val_i,
  output logic [LVL_W-1:0]         pend_lvl_o,
  output logic [SRC_W-1:0]         pend_src_o,
  output logic                     pend_req_o,
  output logic [LVL_W-1:0]         imask_o
);
  import irl_latch_pkg::*;

  logic                         pass;
  logic [GROUPS-1:0][LVL_W-1:0] det;
  logic [GROUPS-1:0][LVL_W-1:0] grp_lvl;

  assign pass = (lvl_mode_e'(lvl_mode_i) == MODE_PASS);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    irl_pin_filter #(.LVL_W(LVL_W)) u_filt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pins_ni    (irl_pins_ni[g*LVL_W +: LVL_W]),
      .en_i       (!grp_irq_mode_i[g] && !grp_mask_i[g]),
      .lvl_mask_i (lvl_mask_i),
      .det_o      (det[g])
    );

    irl_group_hold #(.LVL_W(LVL_W)) u_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .det_i  (det[g]),
      .pass_i (pass),
      .ack_i  (cpu_ack_i),
      .clr_i  (grp_clr_i[g]),
      .off_i  (grp_irq_mode_i[g]),
      .lvl_o  (grp_lvl[g])
    );

    assert_off_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_irq_mode_i[g] |-> (grp_lvl[g] == '0));
  end

  irl_arbiter #(.GROUPS(GROUPS), .LVL_W(LVL_W), .SRC_W(SRC_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (grp_lvl),
    .ack_i       (cpu_ack_i),
    .upd_en_i    (mask_upd_en_i),
    .imask_ld_i  (imask_ld_i),
    .imask_val_i (imask_val_i),
    .pend_lvl_o  (pend_lvl_o),
    .pend_src_o  (pend_src_o),
    .pend_req_o  (pend_req_o),
    .imask_o     (imask_o)
  );
endmodule

// File: tb/irl_level_latch_tb.sv
module irl_level_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins_n = 8'hFF;
  logic        lvl_mode = 1'b1;
  logic [1:0]  irq_mode = '0, grp_mask = '0, grp_clr = '0;
  logic [15:0] lvl_mask = '0;
  logic        ack = 1'b0, upd_en = 1'b0, ld = 1'b0;
  logic [3:0]  ld_val = '0;
  logic [3:0]  pend_lvl, imask;
  logic        pend_src, pend_req;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irl_level_latch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irl_pins_ni(pins_n), .lvl_mode_i(lvl_mode),
    .grp_irq_mode_i(irq_mode), .grp_mask_i(grp_mask), .lvl_mask_i(lvl_mask),
    .grp_clr_i(grp_clr), .cpu_ack_i(ack), .mask_upd_en_i(upd_en),
    .imask_ld_i(ld), .imask_val_i(ld_val), .pend_lvl_o(pend_lvl),
    .pend_src_o(pend_src), .pend_req_o(pend_req), .imask_o(imask)
  );

  // {pins_n[7:0], irq_mode[1:0], exp_lvl[3:0], exp_src}, pass-through mode
  localparam logic [14:0] VEC [10] = '{
    {8'hFF, 2'b00, 4'd0,  1'b0},
    {8'hFA, 2'b00, 4'd5,  1'b0},
    {8'h3F, 2'b00, 4'd12, 1'b1},
    {8'h55, 2'b00, 4'd10, 1'b0},
    {8'h7E, 2'b00, 4'd8,  1'b1},
    {8'h0F, 2'b00, 4'd15, 1'b1},
    {8'h00, 2'b00, 4'd15, 1'b0},
    {8'h3F, 2'b10, 4'd0,  1'b0},
    {8'h30, 2'b01, 4'd12, 1'b1},
    {8'hC9, 2'b00, 4'd6,  1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack(input logic upd);
    ack = 1'b1; upd_en = upd;
    tick(1);
    ack = 1'b0; upd_en = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    grp_clr = m;
    tick(1);
    grp_clr = '0;
  endtask

  task automatic imask_load(input logic [3:0] v);
    ld = 1'b1; ld_val = v;
    tick(1);
    ld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    // R1 reset state
    chk("R1 reset lvl", pend_lvl, 0);
    chk("R1 reset req", pend_req, 0);
    chk("R1 reset src", pend_src, 0);
    chk("R1 reset imask", imask, 0);
    rst_n = 1'b1;
    tick(2);

    // R1 R9 R10 R11 vector table in pass-through mode
    for (int i = 0; i < 10; i++) begin
      pins_n   = VEC[i][14:7];
      irq_mode = VEC[i][6:5];
      tick(5);
      chk($sformatf("R10 vec%0d lvl", i), pend_lvl, VEC[i][4:1]);
      chk($sformatf("R10 vec%0d src", i), pend_src, VEC[i][0]);
      chk($sformatf("R11 vec%0d req", i), pend_req, VEC[i][4:1] != 0);
    end
    irq_mode = '0; pins_n = 8'hFF;
    tick(5);

    // R2 latency: visible after the third edge only
    pins_n = 8'hF9;
    tick(2);
    chk("R2 before third edge", pend_lvl, 0);
    tick(1);
    chk("R2 after third edge", pend_lvl, 6);
    pins_n = 8'hFF;
    tick(5);
    chk("R8 withdraw clears", pend_lvl, 0);
    // R2 single-cycle glitch is never detected
    pins_n = 8'hF0;
    tick(1);
    pins_n = 8'hFF;
    for (int k = 0; k < 5; k++) begin
      chk("R2 glitch rejected", pend_lvl, 0);
      tick(1);
    end

    // R3 R4 retaining mode
    lvl_mode = 1'b0;
    pins_n = 8'hF9; tick(5);
    chk("R3 detect", pend_lvl, 6);
    pins_n = 8'hFF; tick(5);
    chk("R3 kept after withdraw", pend_lvl, 6);
    pins_n = 8'hFC; tick(5);
    chk("R4 lower ignored", pend_lvl, 6);
    pins_n = 8'hF2; tick(5);
    chk("R4 higher replaces", pend_lvl, 13);
    pins_n = 8'hFF; tick(3);
    // R5 acceptance releases
    pulse_ack(1'b0);
    chk("R5 ack release", pend_lvl, 0);

    // R6 per-group clear
    pins_n = 8'h89; tick(5);
    chk("R6 both held lvl", pend_lvl, 7);
    chk("R6 both held src", pend_src, 1);
    pins_n = 8'hFF; tick(5);
    pulse_clr(2'b10);
    chk("R6 clr g1 lvl", pend_lvl, 6);
    chk("R6 clr g1 src", pend_src, 0);
    pulse_clr(2'b01);
    chk("R6 clr g0", pend_lvl, 0);

    // R7 masks
    lvl_mask = 16'h0200; pins_n = 8'hF6; tick(5);
    chk("R7 level mask blocks", pend_lvl, 0);
    lvl_mask = '0; tick(5);
    chk("R7 unmask detects", pend_lvl, 9);
    pins_n = 8'hFF; tick(3);
    pulse_ack(1'b0);
    pins_n = 8'hF9; tick(5);
    grp_mask = 2'b01; pins_n = 8'hF2; tick(5);
    chk("R7 group mask keeps held", pend_lvl, 6);
    lvl_mask = 16'h0040; tick(3);
    chk("R7 level mask keeps held", pend_lvl, 6);
    pins_n = 8'hFF; tick(3);
    grp_mask = '0; lvl_mask = '0; tick(3);
    pulse_ack(1'b0);

    // R9 group removal in retaining mode
    pins_n = 8'h3F; tick(5);
    chk("R9 g1 held", pend_lvl, 12);
    irq_mode = 2'b10; tick(1);
    chk("R9 g1 removed", pend_lvl, 0);
    pins_n = 8'hFF; tick(3);
    irq_mode = '0;
    pulse_ack(1'b0);

    // R11 R12 mask level
    pins_n = 8'hF2; tick(5);
    chk("R11 req above", pend_req, 1);
    imask_load(4'd13);
    chk("R12 direct load", imask, 13);
    chk("R11 req equal blocked", pend_req, 0);
    imask_load(4'd12);
    chk("R11 req above again", pend_req, 1);
    pulse_ack(1'b1);
    chk("R12 accept loads", imask, 13);
    tick(2);
    chk("R11 relatched not above", pend_req, 0);
    imask_load(4'd5);
    pulse_ack(1'b0);
    chk("R12 no update when disabled", imask, 5);
    tick(2);
    // R12 direct load wins over acceptance
    ack = 1'b1; upd_en = 1'b1; ld = 1'b1; ld_val = 4'd2;
    tick(1);
    ack = 1'b0; upd_en = 1'b0; ld = 1'b0;
    chk("R12 load precedence", imask, 2);
    imask_load(4'd0);
    pins_n = 8'hFF; tick(3);
    pulse_ack(1'b0);
    chk("R5 final idle", pend_lvl, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule